// File: doc/BRIEF.md
# Hex Record Stream Loader

This block turns a character stream of colon-led hexadecimal object records into byte writes on a simple memory port. It takes one ASCII character per accepted handshake and assembles hex digit pairs into bytes as they arrive. No record is buffered. Each data byte becomes a write with a full 32-bit address. That address is built from the record's 16-bit offset and whichever base-address extension was last accepted: a 16-bit segment value scaled by sixteen, or an upper-half value placed above the offset.

A running modulo-256 sum covers every byte from the count through the checksum. Once the checksum pair is complete, the block gives a one-cycle verdict, either good or bad. The sink uses this verdict to keep or discard the writes it has already received. Two start-address record kinds are held in output registers and are not written to memory. An end-of-file record raises a sticky flag, and everything after it is ignored. A malformed record raises a format error, and the parser then drops characters until the next colon.

Top module: `hexrec_loader`

## Requirements
- R1: The bytes from the count through the checksum must sum to 0 modulo 256. When they do and the record is well formed, `rec_good` pulses for one cycle. When the sum is nonzero, `rec_bad` and `sum_err` pulse together. Either verdict comes in the cycle after the second checksum character is accepted. The colon and the line terminators are never summed.
- R2: A type 0x00 record writes its data bytes in order. The first byte goes to the record offset and each later byte to the next offset. There is exactly one `wr_en` pulse per byte, in the cycle after that byte's second character. Hex digits 0-9, A-F and a-f are all accepted.
- R3: The offset wraps from 0xFFFF to 0x0000 inside a record. The wrap never carries into the base part of the address.
- R4: An accepted type 0x02 record with count 2 sets a segment value, most significant byte first. Later write addresses are segment*16 + offset. The record also clears the upper-half value.
- R5: An accepted type 0x04 record with count 2 sets the upper-half value, most significant byte first. Later write addresses are upper*65536 + offset. The record also clears the segment. Both base values are zero after reset.
- R6: An accepted type 0x01 record with count 0 sets `eof`, which stays high. After it, no further character causes a write, a verdict or an error pulse.
- R7: An accepted type 0x03 record with count 4 loads `start_cs` from data bytes 0-1 and `start_ip` from bytes 2-3, each most significant byte first, and sets `start_seg_vld`. An accepted type 0x05 record with count 4 loads `start_lin` from bytes 0-3, most significant byte first, and sets `start_lin_vld`.
- R8: Each of these records gets `fmt_err` and `rec_bad` and leaves the base and start registers unchanged:
  - type 0x02 or 0x04 with a count other than 2;
  - type 0x03 or 0x05 with a count other than 4;
  - type 0x01 with a nonzero count;
  - any type above 0x05.
- R9: Inside a record, a character that is not a hex digit (a space, or a CR or LF arriving before the checksum is complete) pulses `fmt_err` and `rec_bad` in the next cycle. Characters are then dropped until the next colon.
- R10: A record may end with CR LF or with LF alone. Characters between records other than a colon are ignored.
- R11: After reset all outputs are zero except `in_ready`, which is high, so a character is accepted on every cycle that `in_valid` is high.
- R12: `rec_good` and `rec_bad` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A character is offered |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Character accepted when valid and ready |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 32 | Absolute write address |
| wr_data | output | 8 | Write data byte |
| rec_good | output | 1 | Record passed its checks |
| rec_bad | output | 1 | Record failed; sink should discard its writes |
| fmt_err | output | 1 | Format fault in the current record |
| sum_err | output | 1 | Checksum mismatch |
| eof | output | 1 | End-of-file record accepted (sticky) |
| start_cs | output | 16 | Segmented start: segment part |
| start_ip | output | 16 | Segmented start: offset part |
| start_seg_vld | output | 1 | Segmented start captured |
| start_lin | output | 32 | Linear start address |
| start_lin_vld | output | 1 | Linear start captured |

## Verification
The bench builds the block with its package defaults: 8-bit characters, a 16-bit offset and a 32-bit address. With those widths, offsets next to 0xFFFF can be reached in a few records. The bench sweeps data records of 0 to 8 bytes over offsets that include the wrap point, and alternates letter case and terminator style. It then computes every expected address from the base value it last set. Separate records cover each extension and start kind, wrong counts, corrupted checksums, stray characters, early line ends and traffic after end of file.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
    parameter int CHAR_W = 8;
    parameter int OFS_W  = 16;
    parameter int ADDR_W = 32;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int EXT_W  = 4 * BYTE_W;

    localparam logic [BYTE_W-1:0] TY_DATA  = 8'h00;
    localparam logic [BYTE_W-1:0] TY_END   = 8'h01;
    localparam logic [BYTE_W-1:0] TY_SEG   = 8'h02;
    localparam logic [BYTE_W-1:0] TY_SSTA  = 8'h03;
    localparam logic [BYTE_W-1:0] TY_UPPER = 8'h04;
    localparam logic [BYTE_W-1:0] TY_LSTA  = 8'h05;

    localparam logic [CHAR_W-1:0] CH_COLON = 8'h3A;
    localparam logic [CHAR_W-1:0] CH_CR    = 8'h0D;
    localparam logic [CHAR_W-1:0] CH_LF    = 8'h0A;

    typedef enum logic [3:0] {
        PS_IDLE, PS_CNT, PS_OFS, PS_TYP, PS_DAT, PS_SUM, PS_EOL, PS_SKIP, PS_DONE
    } pstate_e;
endpackage

// File: rtl/hexrec_nibble.sv
module hexrec_nibble
    import hexrec_pkg::*;
(
    input  logic [CHAR_W-1:0] ch,
    output logic              is_hex,
    output logic [NIB_W-1:0]  value
);
    logic [CHAR_W-1:0] rel;

    always_comb begin
        is_hex = 1'b0;
        value  = '0;
        rel    = '0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            rel    = ch - 8'h30;
            is_hex = 1'b1;
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            rel    = ch - 8'h37;
            is_hex = 1'b1;
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            rel    = ch - 8'h57;
            is_hex = 1'b1;
        end
        value = rel[NIB_W-1:0];
    end
endmodule

// File: rtl/hexrec_addr.sv
module hexrec_addr
    import hexrec_pkg::*;
(
    input  logic [OFS_W-1:0]  upper,
    input  logic [OFS_W-1:0]  seg,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] addr
);
    localparam int SEG_SHIFT = 4;

    logic [ADDR_W-1:0] lin_part;
    logic [ADDR_W-1:0] seg_part;

    always_comb begin
        lin_part = {upper, ofs};
        seg_part = ADDR_W'({seg, {SEG_SHIFT{1'b0}}});
        addr     = lin_part + seg_part;
    end
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rec_good,
    output logic              rec_bad,
    output logic              fmt_err,
    output logic              sum_err,
    output logic              eof,
    output logic [OFS_W-1:0]  start_cs,
    output logic [OFS_W-1:0]  start_ip,
    output logic              start_seg_vld,
    output logic [EXT_W-1:0]  start_lin,
    output logic              start_lin_vld
);
    typedef struct packed {
        pstate_e           st;
        logic              hi_vld;
        logic [NIB_W-1:0]  hi_nib;
        logic              ofs_idx;
        logic [BYTE_W-1:0] cnt;
        logic [BYTE_W-1:0] left;
        logic [BYTE_W-1:0] typ;
        logic [BYTE_W-1:0] acc;
        logic [OFS_W-1:0]  ofs;
        logic [EXT_W-1:0]  ext;
        logic [OFS_W-1:0]  seg;
        logic [OFS_W-1:0]  upper;
        logic [OFS_W-1:0]  cs;
        logic [OFS_W-1:0]  ip;
        logic [EXT_W-1:0]  lin;
        logic              seg_vld;
        logic              lin_vld;
        logic              eof;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
        logic              good;
        logic              bad;
        logic              ferr;
        logic              serr;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              nib_ok;
    logic [NIB_W-1:0]  nib_val;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0] byte_v;
    logic [BYTE_W-1:0] total;
    logic              len_bad;
    logic              field_st;

    hexrec_nibble u_nibble (
        .ch     (in_char),
        .is_hex (nib_ok),
        .value  (nib_val)
    );

    hexrec_addr u_addr (
        .upper (regs_q.upper),
        .seg   (regs_q.seg),
        .ofs   (regs_q.ofs),
        .addr  (cur_addr)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.wr_en = 1'b0;
        regs_d.good  = 1'b0;
        regs_d.bad   = 1'b0;
        regs_d.ferr  = 1'b0;
        regs_d.serr  = 1'b0;

        byte_v = {regs_q.hi_nib, nib_val};
        total  = regs_q.acc + byte_v;

        case (regs_q.typ)
            TY_DATA:          len_bad = 1'b0;
            TY_END:           len_bad = (regs_q.cnt != 8'd0);
            TY_SEG, TY_UPPER: len_bad = (regs_q.cnt != 8'd2);
            TY_SSTA, TY_LSTA: len_bad = (regs_q.cnt != 8'd4);
            default:          len_bad = 1'b1;
        endcase

        field_st = (regs_q.st == PS_CNT) || (regs_q.st == PS_OFS) ||
                   (regs_q.st == PS_TYP) || (regs_q.st == PS_DAT) ||
                   (regs_q.st == PS_SUM);

        if (in_valid) begin
            if (regs_q.st == PS_IDLE || regs_q.st == PS_SKIP) begin
                if (in_char == CH_COLON) begin
                    regs_d.st     = PS_CNT;
                    regs_d.acc    = '0;
                    regs_d.hi_vld = 1'b0;
                    regs_d.ext    = '0;
                end
            end else if (regs_q.st == PS_EOL) begin
                if (in_char == CH_LF) begin
                    regs_d.st = PS_IDLE;
                end else if (in_char != CH_CR) begin
                    regs_d.ferr = 1'b1;
                    regs_d.bad  = 1'b1;
                    regs_d.st   = PS_SKIP;
                end
            end else if (field_st) begin
                if (!nib_ok) begin
                    regs_d.ferr = 1'b1;
                    regs_d.bad  = 1'b1;
                    regs_d.st   = PS_SKIP;
                end else if (!regs_q.hi_vld) begin
                    regs_d.hi_vld = 1'b1;
                    regs_d.hi_nib = nib_val;
                end else begin
                    regs_d.hi_vld = 1'b0;
                    regs_d.acc    = total;
                    case (regs_q.st)
                        PS_CNT: begin
                            regs_d.cnt     = byte_v;
                            regs_d.left    = byte_v;
                            regs_d.ofs_idx = 1'b0;
                            regs_d.st      = PS_OFS;
                        end
                        PS_OFS: begin
                            regs_d.ofs     = {regs_q.ofs[BYTE_W-1:0], byte_v};
                            regs_d.ofs_idx = 1'b1;
                            if (regs_q.ofs_idx) regs_d.st = PS_TYP;
                        end
                        PS_TYP: begin
                            regs_d.typ = byte_v;
                            regs_d.st  = (regs_q.cnt == 8'd0) ? PS_SUM : PS_DAT;
                        end
                        PS_DAT: begin
                            if (regs_q.typ == TY_DATA) begin
                                regs_d.wr_en   = 1'b1;
                                regs_d.wr_addr = cur_addr;
                                regs_d.wr_data = byte_v;
                                regs_d.ofs     = regs_q.ofs + 16'd1;
                            end else begin
                                regs_d.ext = {regs_q.ext[EXT_W-BYTE_W-1:0], byte_v};
                            end
                            regs_d.left = regs_q.left - 8'd1;
                            if (regs_q.left == 8'd1) regs_d.st = PS_SUM;
                        end
                        default: begin
                            regs_d.st = PS_EOL;
                            if (total != 8'd0 || len_bad) begin
                                regs_d.bad  = 1'b1;
                                regs_d.serr = (total != 8'd0);
                                regs_d.ferr = len_bad;
                            end else begin
                                regs_d.good = 1'b1;
                                case (regs_q.typ)
                                    TY_END: begin
                                        regs_d.eof = 1'b1;
                                        regs_d.st  = PS_DONE;
                                    end
                                    TY_SEG: begin
                                        regs_d.seg   = regs_q.ext[OFS_W-1:0];
                                        regs_d.upper = '0;
                                    end
                                    TY_UPPER: begin
                                        regs_d.upper = regs_q.ext[OFS_W-1:0];
                                        regs_d.seg   = '0;
                                    end
                                    TY_SSTA: begin
                                        regs_d.cs      = regs_q.ext[EXT_W-1:OFS_W];
                                        regs_d.ip      = regs_q.ext[OFS_W-1:0];
                                        regs_d.seg_vld = 1'b1;
                                    end
                                    TY_LSTA: begin
                                        regs_d.lin     = regs_q.ext;
                                        regs_d.lin_vld = 1'b1;
                                    end
                                    default: ;
                                endcase
                            end
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign in_ready      = 1'b1;
    assign wr_en         = regs_q.wr_en;
    assign wr_addr       = regs_q.wr_addr;
    assign wr_data       = regs_q.wr_data;
    assign rec_good      = regs_q.good;
    assign rec_bad       = regs_q.bad;
    assign fmt_err       = regs_q.ferr;
    assign sum_err       = regs_q.serr;
    assign eof           = regs_q.eof;
    assign start_cs      = regs_q.cs;
    assign start_ip      = regs_q.ip;
    assign start_seg_vld = regs_q.seg_vld;
    assign start_lin     = regs_q.lin;
    assign start_lin_vld = regs_q.lin_vld;
endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rec_good,
    input logic rec_bad,
    input logic fmt_err,
    input logic sum_err,
    input logic eof
);
    assert_single_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_good && rec_bad));

    assert_sum_err_marks_bad_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sum_err |-> rec_bad);

    assert_good_is_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rec_good |-> (!sum_err && !fmt_err));

    assert_fmt_err_marks_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> rec_bad);

    assert_eof_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> eof);

    assert_quiet_after_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && $past(eof)) |-> (!wr_en && !rec_good && !rec_bad));
endmodule

bind hexrec_loader hexrec_loader_chk u_hexrec_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rec_good (rec_good),
    .rec_bad  (rec_bad),
    .fmt_err  (fmt_err),
    .sum_err  (sum_err),
    .eof      (eof)
);

// File: tb/hexrec_loader_bench.sv
module hexrec_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LOG_DEPTH  = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        in_ready, wr_en, rec_good, rec_bad, fmt_err, sum_err, eof;
    logic [31:0] wr_addr, start_lin;
    logic [7:0]  wr_data;
    logic [15:0] start_cs, start_ip;
    logic        start_seg_vld, start_lin_vld;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hexrec_loader u_hexrec_loader (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rec_good(rec_good), .rec_bad(rec_bad), .fmt_err(fmt_err), .sum_err(sum_err),
        .eof(eof), .start_cs(start_cs), .start_ip(start_ip),
        .start_seg_vld(start_seg_vld), .start_lin(start_lin),
        .start_lin_vld(start_lin_vld)
    );

    int n_checks = 0;
    int n_errs   = 0;
    int nw = 0, n_good = 0, n_bad = 0, n_fmt = 0, n_sum = 0;
    logic [31:0] wlog_addr [LOG_DEPTH];
    logic [7:0]  wlog_data [LOG_DEPTH];
    logic [7:0]  rec_data [256];
    logic [15:0] exp_upper = 16'h0;
    logic [15:0] exp_seg   = 16'h0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en && nw < LOG_DEPTH) begin
                wlog_addr[nw] = wr_addr;
                wlog_data[nw] = wr_data;
            end
            if (wr_en) nw = nw + 1;
            if (rec_good) n_good = n_good + 1;
            if (rec_bad)  n_bad  = n_bad + 1;
            if (fmt_err)  n_fmt  = n_fmt + 1;
            if (sum_err)  n_sum  = n_sum + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hx(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return (lower ? 8'h57 : 8'h37) + {4'h0, n};
    endfunction

    task automatic send_char(input logic [7:0] c);
        in_valid = 1'b1;
        in_char  = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit lower);
        send_char(hx(b[7:4], lower));
        send_char(hx(b[3:0], lower));
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_char(s[i]);
    endtask

    task automatic gap();
        repeat (2) @(negedge clk);
    endtask

    task automatic send_record(input logic [7:0] cnt, input logic [15:0] ofs,
                               input logic [7:0] typ, input bit lower, input bit corrupt);
        logic [7:0] s;
        s = cnt + ofs[15:8] + ofs[7:0] + typ;
        for (int i = 0; i < int'(cnt); i++) s = s + rec_data[i];
        s = 8'h00 - s;
        if (corrupt) s = s ^ 8'h01;
        send_char(8'h3A);
        send_byte(cnt, lower);
        send_byte(ofs[15:8], lower);
        send_byte(ofs[7:0], lower);
        send_byte(typ, lower);
        for (int i = 0; i < int'(cnt); i++) send_byte(rec_data[i], lower);
        send_byte(s, lower);
        if (!lower) send_char(8'h0D);
        send_char(8'h0A);
        gap();
    endtask

    task automatic run_data(input logic [15:0] ofs, input int cnt, input bit lower,
                            input string req);
        int w0, g0, b0;
        logic [31:0] ea;
        w0 = nw; g0 = n_good; b0 = n_bad;
        for (int i = 0; i < cnt; i++) rec_data[i] = 8'(cnt * 31 + i * 7 + int'(ofs));
        send_record(8'(cnt), ofs, 8'h00, lower, 1'b0);
        check(nw - w0 == cnt, req, 32'(nw - w0), 32'(cnt));
        for (int i = 0; i < cnt; i++) begin
            ea = 32'(exp_upper) * 32'd65536 + 32'(exp_seg) * 32'd16
                 + 32'((int'(ofs) + i) % 65536);
            check(wlog_addr[w0 + i] == ea, req, wlog_addr[w0 + i], ea);
            check(wlog_data[w0 + i] == rec_data[i], req, 32'(wlog_data[w0 + i]),
                  32'(rec_data[i]));
        end
        check(n_good - g0 == 1 && n_bad == b0, req, 32'(n_good - g0), 32'd1);
    endtask

    task automatic send_two(input logic [7:0] ty, input logic [15:0] v, input bit bad_len);
        rec_data[0] = v[15:8];
        rec_data[1] = v[7:0];
        rec_data[2] = 8'h77;
        send_record(bad_len ? 8'd3 : 8'd2, 16'h0000, ty, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        int g0, b0, f0, s0, w0;
        logic [15:0] offs [4];
        offs[0] = 16'h0000; offs[1] = 16'h0100; offs[2] = 16'h7FFD; offs[3] = 16'hFFFA;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(in_ready == 1'b1, "R11 ready", 32'(in_ready), 32'd1);
        check({wr_en, rec_good, rec_bad, fmt_err, sum_err, eof} == 6'd0, "R11 flags",
              32'({wr_en, rec_good, rec_bad, fmt_err, sum_err, eof}), 32'd0);
        check(start_lin == 32'd0 && !start_lin_vld && !start_seg_vld, "R11 start",
              start_lin, 32'd0);

        // R2 R3 R10: sweep of counts and offsets, mixed case and terminators
        for (int c = 0; c <= 8; c++)
            for (int k = 0; k < 4; k++)
                run_data(offs[k], c, (c % 2) == 1, "R2 R3 R10 sweep");

        // R10: junk between records ignored
        g0 = n_good; b0 = n_bad; w0 = nw;
        send_str("\r\nxyz 12\r\n");
        gap();
        check(n_good == g0 && n_bad == b0 && nw == w0, "R10 junk", 32'(n_bad - b0), 32'd0);

        // R5 upper-half base
        g0 = n_good;
        send_two(8'h04, 16'h0012, 1'b0);
        check(n_good - g0 == 1, "R5 accept", 32'(n_good - g0), 32'd1);
        exp_upper = 16'h0012;
        run_data(16'h3400, 4, 1'b0, "R5 base");
        run_data(16'hFFFE, 4, 1'b1, "R3 wrap upper");

        // R4 segment base, clears upper
        send_two(8'h02, 16'h1234, 1'b0);
        exp_seg = 16'h1234; exp_upper = 16'h0000;
        run_data(16'hFFF0, 4, 1'b0, "R4 seg");
        run_data(16'hFFFE, 3, 1'b0, "R4 R3 seg wrap");

        // R5 upper clears segment
        send_two(8'h04, 16'hABCD, 1'b0);
        exp_seg = 16'h0000; exp_upper = 16'hABCD;
        run_data(16'h0010, 3, 1'b0, "R5 clears seg");

        // R8 wrong counts leave bases unchanged
        f0 = n_fmt; b0 = n_bad; g0 = n_good;
        send_two(8'h04, 16'h5566, 1'b1);
        check(n_fmt - f0 == 1 && n_bad - b0 == 1 && n_good == g0, "R8 upper len",
              32'(n_fmt - f0), 32'd1);
        f0 = n_fmt;
        send_two(8'h02, 16'h0F0F, 1'b1);
        check(n_fmt - f0 == 1, "R8 seg len", 32'(n_fmt - f0), 32'd1);
        f0 = n_fmt;
        rec_data[0] = 8'h00;
        send_record(8'd1, 16'h0000, 8'h01, 1'b0, 1'b0);
        check(n_fmt - f0 == 1 && eof == 1'b0, "R8 end len", 32'(eof), 32'd0);
        f0 = n_fmt;
        send_record(8'd0, 16'h0000, 8'h07, 1'b0, 1'b0);
        check(n_fmt - f0 == 1, "R8 unknown type", 32'(n_fmt - f0), 32'd1);
        run_data(16'h0020, 2, 1'b0, "R8 base kept");

        // R1 bad checksum
        s0 = n_sum; b0 = n_bad; g0 = n_good; w0 = nw;
        rec_data[0] = 8'h11; rec_data[1] = 8'h22;
        send_record(8'd2, 16'h0040, 8'h00, 1'b0, 1'b1);
        check(n_sum - s0 == 1 && n_bad - b0 == 1 && n_good == g0, "R1 bad sum",
              32'(n_sum - s0), 32'd1);
        check(nw - w0 == 2, "R2 writes before verdict", 32'(nw - w0), 32'd2);
        s0 = n_sum;
        send_str(":0200000400F0FB\r\n");
        gap();
        check(n_sum - s0 == 1, "R1 bad sum ext", 32'(n_sum - s0), 32'd1);
        g0 = n_good;
        send_str(":0200000400F00A\r\n");
        gap();
        check(n_good - g0 == 1, "R1 good literal", 32'(n_good - g0), 32'd1);
        exp_upper = 16'h00F0;
        run_data(16'h0000, 2, 1'b0, "R1 R5 literal base");

        // R9 format faults and recovery
        f0 = n_fmt; b0 = n_bad; w0 = nw;
        send_str(":1G\r\n");
        gap();
        check(n_fmt - f0 == 1 && n_bad - b0 == 1 && nw == w0, "R9 non-hex",
              32'(n_fmt - f0), 32'd1);
        f0 = n_fmt;
        send_str(":0201 0000\n");
        gap();
        check(n_fmt - f0 == 1, "R9 space", 32'(n_fmt - f0), 32'd1);
        f0 = n_fmt; w0 = nw;
        send_str(":04010000AABB\nqq12\n");
        gap();
        check(n_fmt - f0 == 1 && nw - w0 == 2, "R9 early eol", 32'(n_fmt - f0), 32'd1);
        run_data(16'h0300, 3, 1'b1, "R9 recovery");

        // R7 start records
        rec_data[0] = 8'h12; rec_data[1] = 8'h34; rec_data[2] = 8'h56; rec_data[3] = 8'h78;
        send_record(8'd4, 16'h0000, 8'h03, 1'b0, 1'b0);
        check(start_cs == 16'h1234 && start_ip == 16'h5678 && start_seg_vld, "R7 seg start",
              {start_cs, start_ip}, 32'h12345678);
        rec_data[0] = 8'hDE; rec_data[1] = 8'hAD; rec_data[2] = 8'hBE; rec_data[3] = 8'hEF;
        send_record(8'd4, 16'h0000, 8'h05, 1'b1, 1'b0);
        check(start_lin == 32'hDEADBEEF && start_lin_vld, "R7 lin start",
              start_lin, 32'hDEADBEEF);
        run_data(16'h0500, 1, 1'b0, "R7 base untouched");

        // R6 end of file then ignored traffic
        g0 = n_good;
        send_str(":00000001FF\r\n");
        gap();
        check(eof == 1'b1 && n_good - g0 == 1, "R6 eof", 32'(eof), 32'd1);
        g0 = n_good; b0 = n_bad; f0 = n_fmt; w0 = nw;
        rec_data[0] = 8'h99; rec_data[1] = 8'h88;
        send_record(8'd2, 16'h0000, 8'h00, 1'b0, 1'b0);
        send_str(":zz\n");
        gap();
        check(nw == w0 && n_good == g0 && n_bad == b0 && n_fmt == f0, "R6 ignored",
              32'(nw - w0), 32'd0);
        check(eof == 1'b1, "R6 sticky", 32'(eof), 32'd1);

        // R12 verdict counts consistent with pulses
        check(n_good + n_bad > 0, "R12 verdicts seen", 32'(n_good + n_bad), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule